// File: doc/BRIEF.md
# Timer Tick Prescaler and Selector

This block produces one-cycle count-enable pulses for four timer count inputs: timer 0, timer 1, and the low and high halves of timer 2. An 8-bit control register is written and read through a small register port. Each timer's enable comes from one of three sources: a constant enable, which is the system clock rate; a shared prescaled tick; or, for timer 2, an alternate tick that arrives as an input.

The shared prescaled tick is produced in one of two ways. A free-running counter in the system domain divides the system clock by 12, 4 or 48. The other way takes an asynchronous external clock, synchronizes it, detects its rising edges and emits one pulse for every eighth edge. Timers 0 and 1 can run in counter mode. In that mode each one's enable is taken from an external-event enable input and its clock select has no effect. The timer counters, the timer-2 alternate source and the event-pin logic all sit outside this block.

Top module: `tmr_tick_gen`

## Requirements
- R1: The control register resets to 0x00 and is located at address 0x8E. A write to 0x8E stores the written bits. A write to any other address changes nothing. A read of any other address returns 0x00.
- R2: Bits 7 and 2 of the control register always read as 0, whatever value was written to them.
- R3: Bits 1:0 select the prescale ratio. 00 divides the system clock by 12, 01 divides it by 4 and 10 divides it by 48. In each case the prescaled tick is a one-cycle pulse that repeats every N cycles.
- R4: A write that changes bits 1:0 restarts the divider. Count the cycle after the write edge as cycle 1: the first tick appears in cycle N and the next one in cycle 2N.
- R5: Code 11 selects the external clock divided by 8. The external clock is passed through a two-flop synchronizer. One single-cycle tick is produced for every eighth rising edge, counted from the write that selected the mode. The external clock must be no faster than the system clock.
- R6: When timer 0 is not in counter mode, bit 3 selects its enable: 0 gives the prescaled tick and 1 gives a constant enable.
- R7: When timer 1 is not in counter mode, bit 4 selects its enable in the same way as bit 3 does for timer 0.
- R8: In counter mode, the timer 0 or timer 1 enable equals that timer's event-enable input, and bits 3 and 4 have no effect.
- R9: Bit 5 selects the enable for the timer 2 low half: 0 gives the alternate tick and 1 gives a constant enable.
- R10: In split mode, bit 6 selects the enable for the timer 2 high half in the same way as bit 5 does for the low half. Outside split mode, the high-half enable equals the low-half enable and bit 6 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data; 0x00 unless the address matches |
| ext_clk | input | 1 | Asynchronous external clock |
| t0_cnt_mode | input | 1 | Timer 0 is in counter mode |
| t0_evt_en | input | 1 | Timer 0 external-event enable |
| t1_cnt_mode | input | 1 | Timer 1 is in counter mode |
| t1_evt_en | input | 1 | Timer 1 external-event enable |
| t2_split | input | 1 | Timer 2 is in split 8-bit mode |
| t2_alt_tick | input | 1 | Timer 2 alternate tick |
| t0_tick | output | 1 | Timer 0 count enable |
| t1_tick | output | 1 | Timer 1 count enable |
| t2l_tick | output | 1 | Timer 2 low-half count enable |
| t2h_tick | output | 1 | Timer 2 high-half count enable |

## Verification
Two events can land on the same clock edge: a register write that changes the prescale field, and the divider reaching its terminal count. When they coincide, the restart must win, and the old ratio must not leave behind a runt pulse or a doubled pulse. The bench provokes this with random writes in random cycles, against a model counter that restarts on every change of the field. The output is judged in every cycle against the tick position the model predicts. The external-clock mode is checked separately by counting ticks after the 7th, 8th and 16th external rising edges.

// File: rtl/ttg_pkg.sv
// Shared types for the timer tick generator.
// Assumes an 8-bit control register whose field order is fixed by software.
package ttg_pkg;

    typedef enum logic [1:0] {
        PS_DIV_A = 2'b00,
        PS_DIV_B = 2'b01,
        PS_DIV_C = 2'b10,
        PS_EXT   = 2'b11
    } presc_e;

    typedef struct packed {
        logic   rsv_hi;
        logic   t2h_sys;
        logic   t2l_sys;
        logic   t1_sys;
        logic   t0_sys;
        logic   rsv_lo;
        presc_e presc;
    } ctl_t;

    localparam logic [7:0] CTL_WMASK = 8'h7B;

endpackage

// File: rtl/ttg_ctrl_reg.sv
// Control register with a write strobe and an address-decoded read.
// Unused bits are forced to zero. Also flags a write that changes
// the prescale field, so that the dividers can restart on that edge.
module ttg_ctrl_reg
    import ttg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output ctl_t              ctl,
    output logic [7:0]        rdata,
    output logic              presc_chg
);
    logic hit;
    logic [7:0] wmasked;

    // Decode the address and mask off the unused bits.
    always_comb begin
        hit       = (addr == REG_ADDR);
        wmasked   = wdata & CTL_WMASK;
        presc_chg = wr && hit && (wmasked[1:0] != ctl.presc);
        rdata     = hit ? ctl : 8'h00;
    end

    // Hold the register value and update it on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr && hit)
            ctl <= ctl_t'(wmasked);
    end

endmodule

// File: rtl/ttg_sys_div.sv
// Free-running system-clock divider with a selectable ratio.
// Emits a one-cycle tick at terminal count. A restart clears the count,
// so the first tick after a ratio change comes a full period later.
module ttg_sys_div
    import ttg_pkg::*;
#(
    parameter int DIV_A = 12,
    parameter int DIV_B = 4,
    parameter int DIV_C = 48
) (
    input  logic   clk,
    input  logic   rst_n,
    input  presc_e presc,
    input  logic   restart,
    output logic   tick
);
    localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
    localparam int CW     = $clog2(MAX_D);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Choose the terminal count for the active ratio.
    always_comb begin
        case (presc)
            PS_DIV_B: last = CW'(DIV_B - 1);
            PS_DIV_C: last = CW'(DIV_C - 1);
            default:  last = CW'(DIV_A - 1);
        endcase
        tick = (cnt == last);
    end

    // Advance the count, wrap at terminal count, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt >= last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ttg_ext_div.sv
// External-clock divider. The asynchronous input passes through a
// synchronizer chain, rising edges are detected in the system domain, and
// every DIV-th edge gives a one-cycle pulse. Assumes f_ext <= f_sys.
module ttg_ext_div #(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic restart,
    output logic pulse
);
    localparam int EW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [EW-1:0]          ecnt;

    // Build the synchronizer chain, one flop per stage.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_clk;
                end
            end else begin : g_next
                // Shift down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Flag a rising edge and the pulse on the last edge of a group.
    always_comb begin
        rise  = sync_q[SYNC_STAGES-1] && !prev_q;
        pulse = rise && (ecnt == EW'(DIV - 1));
    end

    // Count detected edges modulo DIV, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            ecnt <= '0;
        else if (rise)
            ecnt <= (ecnt == EW'(DIV - 1)) ? '0 : ecnt + 1'b1;
    end

endmodule

// File: rtl/tmr_tick_gen.sv
// Timer tick generator top. Holds the control register, the two prescale
// paths, and the per-timer enable selection. A constant-high enable stands
// for the system clock rate. Counter-mode and split-mode selects are inputs.
module tmr_tick_gen
    import ttg_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E,
    parameter int          DIV_A       = 12,
    parameter int          DIV_B       = 4,
    parameter int          DIV_C       = 48,
    parameter int          EXT_DIV     = 8,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ext_clk,
    input  logic              t0_cnt_mode,
    input  logic              t0_evt_en,
    input  logic              t1_cnt_mode,
    input  logic              t1_evt_en,
    input  logic              t2_split,
    input  logic              t2_alt_tick,
    output logic              t0_tick,
    output logic              t1_tick,
    output logic              t2l_tick,
    output logic              t2h_tick
);
    ctl_t ctl_q;
    logic presc_chg;
    logic sys_tick;
    logic ext_pulse;
    logic pre_tick;

    ttg_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .ctl(ctl_q), .rdata(reg_rdata),
        .presc_chg(presc_chg)
    );

    ttg_sys_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_sdiv (
        .clk(clk), .rst_n(rst_n), .presc(ctl_q.presc),
        .restart(presc_chg), .tick(sys_tick)
    );

    ttg_ext_div #(.DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ediv (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .restart(presc_chg), .pulse(ext_pulse)
    );

    // Pick the shared prescaled tick, then route an enable to each timer.
    always_comb begin
        pre_tick = (ctl_q.presc == PS_EXT) ? ext_pulse : sys_tick;
        t0_tick  = t0_cnt_mode ? t0_evt_en : (ctl_q.t0_sys | pre_tick);
        t1_tick  = t1_cnt_mode ? t1_evt_en : (ctl_q.t1_sys | pre_tick);
        t2l_tick = ctl_q.t2l_sys | t2_alt_tick;
        t2h_tick = t2_split ? (ctl_q.t2h_sys | t2_alt_tick) : t2l_tick;
    end

endmodule

// File: rtl/ttg_chk.sv
// Assertion checker for the timer tick generator, bound to the top.
module ttg_chk #(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [7:0]        ctl,
    input logic              pre_tick,
    input logic              t0_cnt_mode,
    input logic              t0_evt_en,
    input logic              t1_cnt_mode,
    input logic              t1_evt_en,
    input logic              t2_split,
    input logic              t0_tick,
    input logic              t1_tick,
    input logic              t2l_tick,
    input logic              t2h_tick
);
    // R1: a write to a foreign address leaves the register unchanged
    a_r1_foreign_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != REG_ADDR) |=> $stable(ctl));

    // R2: unused bits never read back as one
    a_r2_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] == 1'b0) && (reg_rdata[2] == 1'b0));

    // R3: the prescaled tick is never longer than one cycle
    a_r3_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |=> !pre_tick);

    // R6: constant enable for timer 0 when selected in timer mode
    a_r6_t0_sys_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_cnt_mode && ctl[3]) |-> t0_tick);

    // R7: constant enable for timer 1 when selected in timer mode
    a_r7_t1_sys_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!t1_cnt_mode && ctl[4]) |-> t1_tick);

    // R8: counter mode follows the event enable
    a_r8_t0_event_follow: assert property (@(posedge clk) disable iff (!rst_n)
        t0_cnt_mode |-> (t0_tick == t0_evt_en));
    a_r8_t1_event_follow: assert property (@(posedge clk) disable iff (!rst_n)
        t1_cnt_mode |-> (t1_tick == t1_evt_en));

    // R9: timer 2 low half constant enable when selected
    a_r9_t2l_sys_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[5] |-> t2l_tick);

    // R10: outside split mode both halves share one enable
    a_r10_t2h_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        !t2_split |-> (t2h_tick == t2l_tick));

endmodule

bind tmr_tick_gen ttg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .ctl(ctl_q), .pre_tick(pre_tick),
    .t0_cnt_mode(t0_cnt_mode), .t0_evt_en(t0_evt_en),
    .t1_cnt_mode(t1_cnt_mode), .t1_evt_en(t1_evt_en),
    .t2_split(t2_split), .t0_tick(t0_tick), .t1_tick(t1_tick),
    .t2l_tick(t2l_tick), .t2h_tick(t2h_tick)
);

// File: tb/tmr_tick_gen_tb.sv
// Bench for the timer tick generator: random register traffic and mode
// inputs checked every cycle against a model, plus directed corner cases.
module tmr_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_clk = 1'b0;
    logic       t0_cnt_mode = 1'b0, t0_evt_en = 1'b0;
    logic       t1_cnt_mode = 1'b0, t1_evt_en = 1'b0;
    logic       t2_split = 1'b0, t2_alt_tick = 1'b0;
    logic       t0_tick, t1_tick, t2l_tick, t2h_tick;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] m_reg = 8'h00;
    int  m_cnt = 0;

    always #2 clk = ~clk;

    tmr_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
        .t0_cnt_mode(t0_cnt_mode), .t0_evt_en(t0_evt_en),
        .t1_cnt_mode(t1_cnt_mode), .t1_evt_en(t1_evt_en),
        .t2_split(t2_split), .t2_alt_tick(t2_alt_tick),
        .t0_tick(t0_tick), .t1_tick(t1_tick),
        .t2l_tick(t2l_tick), .t2h_tick(t2h_tick)
    );

    function automatic int div_of(logic [1:0] f);
        case (f)
            2'b01:   return 4;
            2'b10:   return 48;
            default: return 12;
        endcase
    endfunction

    function automatic bit exp_pre();
        return (m_reg[1:0] != 2'b11) && (m_cnt == div_of(m_reg[1:0]) - 1);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model for the current inputs.
    task automatic check_all();
        bit pre_known;
        bit e;
        pre_known = (m_reg[1:0] != 2'b11);
        chk(reg_rdata == ((reg_addr == 8'h8E) ? m_reg : 8'h00), "R1/R2 read",
            int'(reg_rdata), int'((reg_addr == 8'h8E) ? m_reg : 8'h00));
        if (t0_cnt_mode)
            chk(t0_tick == t0_evt_en, "R8 t0 counter mode", t0_tick, t0_evt_en);
        else if (m_reg[3])
            chk(t0_tick == 1'b1, "R6 t0 system enable", t0_tick, 1);
        else if (pre_known)
            chk(t0_tick == exp_pre(), "R3/R4/R6 t0 prescaled", t0_tick, exp_pre());
        if (t1_cnt_mode)
            chk(t1_tick == t1_evt_en, "R8 t1 counter mode", t1_tick, t1_evt_en);
        else if (m_reg[4])
            chk(t1_tick == 1'b1, "R7 t1 system enable", t1_tick, 1);
        else if (pre_known)
            chk(t1_tick == exp_pre(), "R3/R4/R7 t1 prescaled", t1_tick, exp_pre());
        e = m_reg[5] | t2_alt_tick;
        chk(t2l_tick == e, "R9 t2 low", t2l_tick, e);
        e = t2_split ? (m_reg[6] | t2_alt_tick) : e;
        chk(t2h_tick == e, "R10 t2 high", t2h_tick, e);
    endtask

    // One clock: update the model at the edge, check at the falling edge.
    task automatic step();
        logic [7:0] nv;
        @(posedge clk);
        if (reg_wr && reg_addr == 8'h8E) begin
            nv = reg_wdata & 8'h7B;
            if (nv[1:0] != m_reg[1:0]) m_cnt = 0;
            else m_cnt = (m_cnt == div_of(m_reg[1:0]) - 1) ? 0 : m_cnt + 1;
            m_reg = nv;
        end else begin
            m_cnt = (m_cnt == div_of(m_reg[1:0]) - 1) ? 0 : m_cnt + 1;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic write(logic [7:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 8'h8E;
    endtask

    // Measure the first and second tick positions after a field change.
    task automatic ratio_case(logic [7:0] d, int n, string req);
        int first = 0;
        int second = 0;
        write(8'h8E, d);
        if (t0_tick && first == 0) first = 1;
        for (int k = 2; k <= 2 * n + 2; k++) begin
            step();
            if (t0_tick) begin
                if (first == 0) first = k;
                else if (second == 0) second = k;
            end
        end
        chk(first == n, req, first, n);
        chk(second == 2 * n, req, second, 2 * n);
    endtask

    initial begin
        int seed;
        int ecount;
        seed = 32'h5EED_7A11;
        void'($urandom(seed));
        reg_addr = 8'h8E;
        repeat (4) @(negedge clk);
        chk(reg_rdata == 8'h00, "R1 reset value", int'(reg_rdata), 0);
        rst_n = 1'b1;
        m_reg = 8'h00; m_cnt = 0;
        step();

        // R1: write to a foreign address, then to the register itself
        write(8'h8F, 8'h58);
        chk(reg_rdata == 8'h00, "R1 foreign write ignored", int'(reg_rdata), 0);
        reg_addr = 8'h8F; #0;
        #1 chk(reg_rdata == 8'h00, "R1 foreign read", int'(reg_rdata), 0);
        reg_addr = 8'h8E;
        // R2: all ones reads back with unused bits clear
        write(8'h8E, 8'hFF);
        #1 chk(reg_rdata == 8'h7B, "R2 unused bits", int'(reg_rdata), 8'h7B);
        write(8'h8E, 8'h00);

        // R3/R4: ratios and restart
        ratio_case(8'h02, 48, "R3/R4 div48");
        ratio_case(8'h00, 12, "R3/R4 div12");
        ratio_case(8'h01, 4,  "R3/R4 div4");

        // Random traffic; prescale field never 11 here
        for (int i = 0; i < 3000; i++) begin
            t0_cnt_mode = 1'($urandom); t0_evt_en = 1'($urandom);
            t1_cnt_mode = 1'($urandom); t1_evt_en = 1'($urandom);
            t2_split = 1'($urandom); t2_alt_tick = 1'($urandom);
            if (($urandom % 16) == 0) begin
                reg_wr = 1'b1;
                reg_addr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h8E;
                reg_wdata = 8'($urandom);
                if (reg_wdata[1:0] == 2'b11) reg_wdata[1:0] = 2'b00;
            end else begin
                reg_wr = 1'b0;
                reg_addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h8E;
            end
            step();
        end
        reg_wr = 1'b0; reg_addr = 8'h8E;

        // R5: external clock divided by 8
        t0_cnt_mode = 1'b0; t1_cnt_mode = 1'b0;
        ext_clk = 1'b0;
        write(8'h8E, 8'h03);
        ecount = 0;
        for (int e = 1; e <= 16; e++) begin
            ext_clk = 1'b1;
            repeat (3) begin step(); if (t0_tick) ecount++; end
            ext_clk = 1'b0;
            repeat (3) begin step(); if (t0_tick) ecount++; end
            if (e == 7)  chk(ecount == 0, "R5 no tick before 8th edge", ecount, 0);
            if (e == 8)  chk(ecount == 1, "R5 tick on 8th edge", ecount, 1);
            if (e == 16) chk(ecount == 2, "R5 tick on 16th edge", ecount, 2);
        end
        chk(t1_tick == t0_tick, "R7 t1 shares ext tick", t1_tick, t0_tick);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule